// File: doc/BRIEF.md
# Circuit-Switched Memory Gateway Sequencer

This block sequences one memory access point. Read and write requests arrive as control messages over an electronic network. The block queues them and takes them one at a time. For each one it sets up a circuit through the local switch toward the target memory module, exchanges path messages with the requesting processor gateway, and drives the row and then the column address to the module. It releases the circuit once the transfer is over. No accesses contend here: each circuit is reserved end to end before any data moves.

A read and a write use different orderings. For a read, the command path and the module-to-network return path are connected first. A path-setup message then goes to the requester, and the addresses wait until the requester's path acknowledge arrives. For a write, the request itself counts as the path setup. The command path is connected, the addresses are sent, and then the network-to-module path is connected and the acknowledge goes out. The length of every access is known when the request arrives, so the block counts the data beats itself and tears the path down without any end-of-data marker. If a read's acknowledge does not come back within a fixed window, the circuit is dropped and an error message is returned.

Top module: `circ_mem_gateway`

## Requirements
- R1: After reset every switch, message, command and done output is 0 and `req_ready` is 1.
- R2: For a read, `sw_cmd_en` and `sw_rd_en` are both 1, with `sw_module` equal to the request's module, in the first cycle after the request is taken from the queue. `path_setup` pulses in that same cycle, before any address goes out.
- R3: For a read, no address goes out until `path_ack` is sampled high. The row (`cmd_col`=0) appears in the cycle after the acknowledge is captured, and the column (`cmd_col`=1) appears in the cycle after that. `cmd_addr` carries the request's row or column, zero-extended.
- R4: The data phase lasts `req_len`+1 cycles, and `data_done` is high in its last cycle. In the cycle after `data_done`, all switch enables are 0.
- R5: For a write, no `path_setup` is sent. The row appears 2 cycles after the request is taken and the column 1 cycle after the row. Then `sw_wr_en` rises, and `wr_ack` pulses in the first data cycle. `cmd_write` is 1 on the write's address cycles.
- R6: If `path_ack` is not sampled within TIMEOUT cycles of the read entering its wait, the block releases all switch enables and pulses `err_resp` TIMEOUT+1 cycles after `path_setup`. No address is sent. An acknowledge in the last cycle of the window is accepted.
- R7: `path_ack` has no effect outside the read's wait for the acknowledge. Timing and outputs are unchanged.
- R8: Requests are queued, up to QDEPTH of them, and served in arrival order. While the queue is full, `req_ready` is 0 and a request presented then is dropped.
- R9: `sw_rd_en` is never 1 for a write, `sw_wr_en` is never 1 for a read, and `rsp_remote` carries the request's origin bit whenever `path_setup`, `wr_ack` or `err_resp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request message present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_remote | input | 1 | 1 = remote processor, 0 = local |
| req_module | input | MOD_W | Target memory module |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_len | input | LEN_W | Data beats minus one |
| req_ready | output | 1 | Queue can accept a request |
| path_ack | input | 1 | Path acknowledge from requester (read) |
| path_setup | output | 1 | Path-setup message to requester (read) |
| wr_ack | output | 1 | Acknowledge to requester (write) |
| err_resp | output | 1 | Error response (acknowledge timeout) |
| rsp_remote | output | 1 | Origin bit of the message being sent |
| sw_cmd_en | output | 1 | Command modulators connected to module |
| sw_rd_en | output | 1 | Module connected to network |
| sw_wr_en | output | 1 | Network connected to module |
| sw_module | output | MOD_W | Module the switch points at |
| cmd_valid | output | 1 | Address command valid |
| cmd_col | output | 1 | 0 = row address, 1 = column address |
| cmd_write | output | 1 | Command belongs to a write |
| cmd_addr | output | max(ROW_W,COL_W) | Address value |
| data_done | output | 1 | Last data beat of the transfer |

## Verification
A wrong state or timer value in this block shows up at the ports within one cycle. An address might appear without its acknowledge, the switch might stay connected after `data_done`, the timeout error might come one cycle early or late, or the beat count might be off by one. The bench sweeps every burst length in both directions, every acknowledge delay up to and past the timeout, and a queue overflow. It times each event against arithmetic expectations, so a single-cycle slip in any state is reported.

// File: rtl/mgw_pkg.sv
package mgw_pkg;
    typedef enum logic [2:0] {
        GW_IDLE,
        GW_CFG_SW,
        GW_SETUP_WAIT,
        GW_ADDR,
        GW_DATA,
        GW_TEARDOWN
    } gw_state_e;
endpackage

// File: rtl/mgw_req_queue.sv
module mgw_req_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         not_empty,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } q_regs_t;

    q_regs_t r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (r_q.cnt == CW'(DEPTH));
    assign not_empty = (r_q.cnt != '0);
    assign head      = mem_q[r_q.rd];
    assign push_ok   = push && !full;
    assign pop_ok    = pop && not_empty;

    always_comb begin
        r_d = r_q;
        if (push_ok) r_d.wr = bump(r_q.wr);
        if (pop_ok)  r_d.rd = bump(r_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[r_q.wr] <= push_data;
    end
endmodule

// File: rtl/mgw_seq_fsm.sv
module mgw_seq_fsm
    import mgw_pkg::*;
#(
    parameter int MOD_W   = 2,
    parameter int ROW_W   = 6,
    parameter int COL_W   = 5,
    parameter int LEN_W   = 3,
    parameter int TIMEOUT = 6,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic              q_write,
    input  logic              q_remote,
    input  logic [MOD_W-1:0]  q_module,
    input  logic [ROW_W-1:0]  q_row,
    input  logic [COL_W-1:0]  q_col,
    input  logic [LEN_W-1:0]  q_len,
    output logic              q_pop,
    input  logic              path_ack,
    output logic              path_setup,
    output logic              wr_ack,
    output logic              err_resp,
    output logic              rsp_remote,
    output logic              sw_cmd_en,
    output logic              sw_rd_en,
    output logic              sw_wr_en,
    output logic [MOD_W-1:0]  sw_module,
    output logic              cmd_valid,
    output logic              cmd_col,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              data_done
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        gw_state_e        st;
        logic             phase;
        logic             err;
        logic [TMR_W-1:0] tmr;
        logic [LEN_W-1:0] cnt;
        logic             wr;
        logic             rem;
        logic [MOD_W-1:0] mod;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] len;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic active, in_data, msg;

    always_comb begin
        r_d   = r_q;
        q_pop = 1'b0;
        case (r_q.st)
            GW_IDLE: begin
                if (q_valid) begin
                    q_pop     = 1'b1;
                    r_d.wr    = q_write;
                    r_d.rem   = q_remote;
                    r_d.mod   = q_module;
                    r_d.row   = q_row;
                    r_d.col   = q_col;
                    r_d.len   = q_len;
                    r_d.err   = 1'b0;
                    r_d.phase = 1'b0;
                    r_d.st    = GW_CFG_SW;
                end
            end
            GW_CFG_SW: begin
                r_d.tmr = '0;
                r_d.st  = r_q.wr ? GW_ADDR : GW_SETUP_WAIT;
            end
            GW_SETUP_WAIT: begin
                if (path_ack) begin
                    r_d.st = GW_ADDR;
                end else if (r_q.tmr == TMR_W'(TIMEOUT - 1)) begin
                    r_d.err = 1'b1;
                    r_d.st  = GW_TEARDOWN;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            GW_ADDR: begin
                if (!r_q.phase) begin
                    r_d.phase = 1'b1;
                end else begin
                    r_d.phase = 1'b0;
                    r_d.cnt   = r_q.len;
                    r_d.st    = GW_DATA;
                end
            end
            GW_DATA: begin
                if (r_q.cnt == '0) r_d.st  = GW_TEARDOWN;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            GW_TEARDOWN: r_d.st = GW_IDLE;
            default:     r_d.st = GW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active     = (r_q.st == GW_CFG_SW) || (r_q.st == GW_SETUP_WAIT) ||
                        (r_q.st == GW_ADDR)   || (r_q.st == GW_DATA);
    assign in_data    = (r_q.st == GW_DATA);
    assign sw_cmd_en  = active;
    assign sw_rd_en   = active && !r_q.wr;
    assign sw_wr_en   = in_data && r_q.wr;
    assign sw_module  = active ? r_q.mod : '0;
    assign path_setup = (r_q.st == GW_CFG_SW) && !r_q.wr;
    assign wr_ack     = in_data && r_q.wr && (r_q.cnt == r_q.len);
    assign err_resp   = (r_q.st == GW_TEARDOWN) && r_q.err;
    assign msg        = path_setup || wr_ack || err_resp;
    assign rsp_remote = msg && r_q.rem;
    assign cmd_valid  = (r_q.st == GW_ADDR);
    assign cmd_col    = cmd_valid && r_q.phase;
    assign cmd_write  = cmd_valid && r_q.wr;
    assign cmd_addr   = !cmd_valid ? '0 :
                        (r_q.phase ? ADDR_W'(r_q.col) : ADDR_W'(r_q.row));
    assign data_done  = in_data && (r_q.cnt == '0);
endmodule

// File: rtl/circ_mem_gateway.sv
module circ_mem_gateway #(
    parameter int MOD_W   = 2,
    parameter int ROW_W   = 6,
    parameter int COL_W   = 5,
    parameter int LEN_W   = 3,
    parameter int TIMEOUT = 6,
    parameter int QDEPTH  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_remote,
    input  logic [MOD_W-1:0]  req_module,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic              path_ack,
    output logic              path_setup,
    output logic              wr_ack,
    output logic              err_resp,
    output logic              rsp_remote,
    output logic              sw_cmd_en,
    output logic              sw_rd_en,
    output logic              sw_wr_en,
    output logic [MOD_W-1:0]  sw_module,
    output logic              cmd_valid,
    output logic              cmd_col,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              data_done
);
    localparam int REQ_W = 2 + MOD_W + ROW_W + COL_W + LEN_W;

    logic             q_full, q_valid, q_pop;
    logic [REQ_W-1:0] q_head;
    logic             h_write, h_remote;
    logic [MOD_W-1:0] h_module;
    logic [ROW_W-1:0] h_row;
    logic [COL_W-1:0] h_col;
    logic [LEN_W-1:0] h_len;

    assign req_ready = !q_full;
    assign {h_write, h_remote, h_module, h_row, h_col, h_len} = q_head;

    mgw_req_queue #(.W(REQ_W), .DEPTH(QDEPTH)) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid),
        .push_data ({req_write, req_remote, req_module, req_row, req_col, req_len}),
        .pop       (q_pop),
        .full      (q_full),
        .not_empty (q_valid),
        .head      (q_head)
    );

    mgw_seq_fsm #(
        .MOD_W(MOD_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .LEN_W(LEN_W), .TIMEOUT(TIMEOUT)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_valid    (q_valid),
        .q_write    (h_write),
        .q_remote   (h_remote),
        .q_module   (h_module),
        .q_row      (h_row),
        .q_col      (h_col),
        .q_len      (h_len),
        .q_pop      (q_pop),
        .path_ack   (path_ack),
        .path_setup (path_setup),
        .wr_ack     (wr_ack),
        .err_resp   (err_resp),
        .rsp_remote (rsp_remote),
        .sw_cmd_en  (sw_cmd_en),
        .sw_rd_en   (sw_rd_en),
        .sw_wr_en   (sw_wr_en),
        .sw_module  (sw_module),
        .cmd_valid  (cmd_valid),
        .cmd_col    (cmd_col),
        .cmd_write  (cmd_write),
        .cmd_addr   (cmd_addr),
        .data_done  (data_done)
    );
endmodule

// File: rtl/mgw_checker.sv
module mgw_checker (
    input logic clk,
    input logic rst_n,
    input logic path_setup,
    input logic wr_ack,
    input logic err_resp,
    input logic sw_cmd_en,
    input logic sw_rd_en,
    input logic sw_wr_en,
    input logic cmd_valid,
    input logic cmd_col,
    input logic cmd_write,
    input logic data_done
);
    assert_cmd_needs_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> sw_cmd_en);
    assert_read_return_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |-> sw_rd_en);
    assert_no_addr_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        path_setup |=> !cmd_valid);
    assert_row_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_col) |=> (cmd_valid && cmd_col));
    assert_release_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> (!sw_cmd_en && !sw_rd_en && !sw_wr_en));
    assert_ack_with_wr_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (sw_wr_en && !sw_rd_en));
    assert_err_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_resp |-> (!sw_cmd_en && !cmd_valid && !data_done));
    assert_paths_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_rd_en && sw_wr_en));
    assert_one_message_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({path_setup, wr_ack, err_resp}) <= 1);
endmodule

bind circ_mem_gateway mgw_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_setup (path_setup),
    .wr_ack     (wr_ack),
    .err_resp   (err_resp),
    .sw_cmd_en  (sw_cmd_en),
    .sw_rd_en   (sw_rd_en),
    .sw_wr_en   (sw_wr_en),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .cmd_write  (cmd_write),
    .data_done  (data_done)
);

// File: tb/circ_mem_gateway_tb_top.sv
module circ_mem_gateway_tb_top;
    localparam int TO = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_remote = 1'b0;
    logic [1:0] req_module = '0;
    logic [5:0] req_row = '0;
    logic [4:0] req_col = '0;
    logic [2:0] req_len = '0;
    logic       path_ack = 1'b0;
    logic       req_ready, path_setup, wr_ack, err_resp, rsp_remote;
    logic       sw_cmd_en, sw_rd_en, sw_wr_en, cmd_valid, cmd_col, cmd_write, data_done;
    logic [1:0] sw_module;
    logic [5:0] cmd_addr;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    circ_mem_gateway dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_remote(req_remote), .req_module(req_module), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .req_ready(req_ready),
        .path_ack(path_ack), .path_setup(path_setup), .wr_ack(wr_ack),
        .err_resp(err_resp), .rsp_remote(rsp_remote), .sw_cmd_en(sw_cmd_en),
        .sw_rd_en(sw_rd_en), .sw_wr_en(sw_wr_en), .sw_module(sw_module),
        .cmd_valid(cmd_valid), .cmd_col(cmd_col), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .data_done(data_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_req(input bit wr, input bit rem, input int mod,
                             input int row, input int col, input int len);
        req_valid  = 1'b1;
        req_write  = wr;
        req_remote = rem;
        req_module = mod[1:0];
        req_row    = row[5:0];
        req_col    = col[4:0];
        req_len    = len[2:0];
    endtask

    // One transaction on an idle block; s counts samples after the push edge.
    task automatic run_txn(input bit wr, input bit rem, input int mod, input int row,
                           input int col, input int len, input int dly, input bit stray);
        int setup_s = 0, row_s = 0, col_s = 0, ack_s = 0, done_s = 0, err_s = 0;
        int td_s = 0, wr_cnt = 0, row_a = -1, col_a = -1, mod_a = -1, rem_a = -1;
        int rd_bad = 0, wrflag_a = -1;
        bit seen_on = 0;
        @(negedge clk);
        drive_req(wr, rem, mod, row, col, len);
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 1; s <= 60; s++) begin
            if (path_setup && setup_s == 0) begin
                setup_s = s; rem_a = rsp_remote;
                if (!(sw_cmd_en && sw_rd_en)) rd_bad++;
            end
            if (wr_ack && ack_s == 0) begin ack_s = s; rem_a = rsp_remote; end
            if (err_resp && err_s == 0) begin err_s = s; rem_a = rsp_remote; end
            if (cmd_valid && !cmd_col && row_s == 0) begin
                row_s = s; row_a = cmd_addr; mod_a = sw_module; wrflag_a = cmd_write;
                if (sw_rd_en == wr) rd_bad++;
            end
            if (cmd_valid && cmd_col && col_s == 0) begin col_s = s; col_a = cmd_addr; end
            if (data_done && done_s == 0) done_s = s;
            if (sw_wr_en) wr_cnt++;
            if (sw_wr_en && !wr) rd_bad++;
            if (sw_cmd_en) seen_on = 1;
            else if (seen_on && td_s == 0) td_s = s;
            path_ack = (!wr && setup_s != 0 && s == setup_s + dly) ||
                       (stray && row_s != 0 && s == row_s);
            @(negedge clk);
        end
        path_ack = 1'b0;
        chk("R9 path enables match direction", rd_bad, 0);
        if (wr) begin
            chk("R5 write sends no setup", setup_s, 0);
            chk("R5 write row cycle", row_s, 3);
            chk("R5 write col cycle", col_s, 4);
            chk("R5 write ack cycle", ack_s, 5);
            chk("R5 cmd_write on address", wrflag_a, 1);
            chk("R4 write done cycle", done_s, 5 + len);
            chk("R4 write beats", wr_cnt, len + 1);
            chk("R4 write release cycle", td_s, 6 + len);
            chk("R9 write origin bit", rem_a, rem);
            if (stray) chk("R7 stray ack leaves write timing", done_s, 5 + len);
        end else if (dly <= TO) begin
            chk("R2 read setup cycle", setup_s, 2);
            chk("R3 read row after ack", row_s, 3 + dly);
            chk("R3 read col after row", col_s, 4 + dly);
            chk("R3 read no wr_ack", ack_s, 0);
            chk("R4 read done cycle", done_s, 5 + dly + len);
            chk("R4 read release cycle", td_s, 6 + dly + len);
            chk("R6 no error on ack in window", err_s, 0);
            chk("R9 read origin bit", rem_a, rem);
        end else begin
            chk("R2 read setup cycle (timeout case)", setup_s, 2);
            chk("R6 timeout error cycle", err_s, 3 + TO);
            chk("R6 timeout release cycle", td_s, 3 + TO);
            chk("R6 no address on timeout", row_s, 0);
            chk("R7 late ack ignored, no data", done_s, 0);
            chk("R9 error origin bit", rem_a, rem);
        end
        if (row_s != 0) begin
            chk("R3 row value", row_a, row & 63);
            chk("R3 col value", col_a, col & 31);
            chk("R2 switch module", mod_a, mod & 3);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int rows_seen [$];
        int dones;
        repeat (3) @(negedge clk);
        chk("R1 reset switch", {sw_cmd_en, sw_rd_en, sw_wr_en}, 0);
        chk("R1 reset messages", {path_setup, wr_ack, err_resp, cmd_valid, data_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 idle outputs", {sw_cmd_en, cmd_valid, data_done, sw_module}, 0);

        for (int l = 0; l < 8; l++)
            run_txn(1'b0, l[0], l % 4, 10 + l, 3 * l, l, 1, 1'b0);
        for (int d = 1; d <= TO; d++)
            run_txn(1'b0, 1'b1, d % 4, 40 + d, 20 + d, 2, d, 1'b0);
        run_txn(1'b0, 1'b1, 2, 5, 6, 3, TO + 1, 1'b0);
        run_txn(1'b0, 1'b0, 1, 5, 6, 3, TO + 5, 1'b0);
        for (int l = 0; l < 8; l++)
            run_txn(1'b1, ~l[0], (l + 1) % 4, 63 - l, 31 - l, l, 0, l[1]);
        run_txn(1'b0, 1'b0, 3, 7, 9, 1, 2, 1'b1);

        // R8: fill queue behind a read that times out
        @(negedge clk);
        drive_req(1'b0, 1'b0, 0, 1, 1, 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk("R8 ready while space", req_ready, 1);
            drive_req(1'b1, 1'b0, 1, 20 + k, k, 1);
            @(negedge clk);
        end
        chk("R8 ready low when full", req_ready, 0);
        drive_req(1'b1, 1'b0, 1, 50, 0, 1);
        @(negedge clk);
        req_valid = 1'b0;
        dones = 0;
        for (int s = 0; s < 120; s++) begin
            if (cmd_valid && !cmd_col) rows_seen.push_back(cmd_addr);
            if (data_done) dones++;
            @(negedge clk);
        end
        chk("R8 served count", rows_seen.size(), 4);
        chk("R8 transfers done", dones, 4);
        for (int k = 0; k < 4; k++)
            if (k < rows_seen.size()) chk("R8 arrival order", rows_seen[k], 20 + k);
        chk("R8 ready after drain", req_ready, 1);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule